// File: doc/BRIEF.md
# Three-Wire Serial Configuration EEPROM Master

This block drives a 64-word by 16-bit serial EEPROM over a three-wire link. The link has a chip select, a serial clock and a data line toward the memory, plus one data line back. A client issues one command at a time on a small command port: read a word, write a word, erase a word, or enable or disable programming. The block then shifts the instruction out with the link timing the memory needs. For a read it returns the word with a one-cycle strobe.

The serial clock is derived from the system clock. One half period lasts `HALF_CYC` system cycles, and every link timing window is a whole number of half periods. The default of 375 cycles at 250 MHz gives 1.5 us halves, which is about 333 kHz. That satisfies the 200 to 400 kHz clock range, the 500 ns minimum for the high and low phases, and the 1 us setup and hold windows on chip select and data.

After a write or an erase, the memory programs internally. The block drops chip select for one serial clock period, raises it again, and watches the return line until the memory reports ready.

Top module: `uwire_eeprom_master`

## Requirements
- R1: Each instruction is shifted out MSB first as a start bit 1, a 2-bit opcode and a 6-bit address field. `cmd_op` selects the instruction:
  - 0: read, opcode 10.
  - 1: write, opcode 01, followed by the 16 data bits MSB first.
  - 2: erase, opcode 11.
  - 3: programming enable, opcode 00 with address field 110000.
  - 4: programming disable, opcode 00 with address field 000000.
  - Codes 5 to 7 act as programming disable.
- R2: While chip select is high and bits are being shifted, every high phase and every low phase of the serial clock lasts exactly `HALF_CYC` cycles. The serial clock is never high while chip select is low.
- R3: Chip select rises exactly `HALF_CYC` cycles before the first serial clock rising edge. Chip select falls exactly `HALF_CYC` cycles after the last serial clock falling edge of the instruction.
- R4: The outgoing data line changes only while the serial clock is low (at a falling edge or when chip select rises). It therefore has a full half period of setup before each rising edge and of hold after it.
- R5: A read clocks 17 further bits after the address and samples the return line at each rising edge. The first sample is the dummy bit and is discarded. The next 16 form `rd_data`, MSB first. `rd_valid` is a single-cycle pulse on the cycle chip select drops.
- R6: After a write or erase instruction, chip select stays low for exactly 2·`HALF_CYC` cycles and then rises again. The return line is then sampled once every `HALF_CYC` cycles, and chip select drops at the first sample that reads high, never before it.
- R7: `busy` is high from the cycle after a command is accepted until the final chip select drop, and falls on that same cycle. Chip select is never high while `busy` is low.
- R8: A command presented while `busy` is high is ignored. It neither starts a second instruction nor alters the one in progress.
- R9: Reset, synchronous and active low, drives chip select, serial clock, outgoing data, `busy` and `rd_valid` low, including when it is applied in the middle of an instruction.
- R10: Programming enable, programming disable and read instructions raise chip select only once. There is no ready polling after them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command request, taken when `busy` is low |
| cmd_op | input | 3 | Instruction select (encoding in R1) |
| cmd_addr | input | ADDR_W | Word address |
| cmd_wdata | input | DATA_W | Word to write |
| busy | output | 1 | Instruction in progress |
| rd_valid | output | 1 | Read word ready, one cycle |
| rd_data | output | DATA_W | Word returned by the last read |
| ee_cs | output | 1 | Chip select to the memory |
| ee_sk | output | 1 | Serial clock to the memory |
| ee_di | output | 1 | Serial data to the memory |
| ee_do | input | 1 | Serial data from the memory |

## Verification
The assertions assume that `ee_do` is already synchronous to `clk`, so the block samples it directly without a synchronizer. They also assume that after programming the memory eventually drives the line high, since the polling loop has no limit, and that `HALF_CYC` is at least 2. The bench memory model meets these assumptions by driving the return line from logic clocked by `clk`, by changing read data only on serial clock falling edges, and by reporting ready a fixed 40 cycles after chip select returns. The bench shortens `HALF_CYC` to 8 so that many instructions fit in the run. This does not change any cycle relation the requirements state.

// File: rtl/uwire_pkg.sv
`timescale 1ns/1ps
// Shared types for the three-wire EEPROM master.
// Assumes nothing beyond the SystemVerilog-2017 type system.
package uwire_pkg;

    // Command codes on the client port
    typedef enum logic [2:0] {
        OP_READ  = 3'd0,
        OP_WRITE = 3'd1,
        OP_ERASE = 3'd2,
        OP_WREN  = 3'd3,
        OP_WRDIS = 3'd4
    } uw_op_e;

    // Link sequencer states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_HOLD,
        ST_GAP,
        ST_POLL
    } uw_state_e;

endpackage

// File: rtl/uwire_half_timer.sv
`timescale 1ns/1ps
// Half-period timer: pulses tick once every HALF_CYC cycles.
// Restarts from zero when clr is high, so the first tick after a restart
// comes a full half period later. Assumes HALF_CYC >= 2.
module uwire_half_timer #(
    parameter int HALF_CYC = 375
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = $clog2(HALF_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt;

    assign tick = (cnt == LAST);

    // Count cycles within the current half period
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    // Ticks are spaced HALF_CYC apart, so never back to back
    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/uwire_frame_enc.sv
`timescale 1ns/1ps
// Instruction encoder: turns a client command into a left-aligned bit
// frame plus the counts of outgoing and incoming bit cells.
// Purely combinational; assumes ADDR_W >= 2.
module uwire_frame_enc
    import uwire_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int DATA_W  = 16,
    parameter int FRAME_W = 3 + ADDR_W + DATA_W,
    parameter int LW      = $clog2(FRAME_W + DATA_W + 2)
) (
    input  uw_op_e             op,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [FRAME_W-1:0] frame,
    output logic [LW-1:0]      out_len,
    output logic [LW-1:0]      rx_len,
    output logic               need_poll,
    output logic               is_read
);
    localparam logic [LW-1:0] INSTR_LEN = LW'(3 + ADDR_W);
    localparam logic [LW-1:0] WRITE_LEN = LW'(3 + ADDR_W + DATA_W);
    localparam logic [LW-1:0] READ_RX   = LW'(DATA_W + 1);
    localparam logic [ADDR_W-1:0] EN_FIELD  = {2'b11, {(ADDR_W-2){1'b0}}};
    localparam logic [ADDR_W-1:0] DIS_FIELD = '0;

    // Pick opcode, address field, payload and cell counts per command
    always_comb begin
        frame     = '0;
        out_len   = INSTR_LEN;
        rx_len    = '0;
        need_poll = 1'b0;
        is_read   = 1'b0;
        case (op)
            OP_READ: begin
                frame   = {1'b1, 2'b10, addr, {DATA_W{1'b0}}};
                rx_len  = READ_RX;
                is_read = 1'b1;
            end
            OP_WRITE: begin
                frame     = {1'b1, 2'b01, addr, wdata};
                out_len   = WRITE_LEN;
                need_poll = 1'b1;
            end
            OP_ERASE: begin
                frame     = {1'b1, 2'b11, addr, {DATA_W{1'b0}}};
                need_poll = 1'b1;
            end
            OP_WREN: frame = {1'b1, 2'b00, EN_FIELD, {DATA_W{1'b0}}};
            default: frame = {1'b1, 2'b00, DIS_FIELD, {DATA_W{1'b0}}};
        endcase
    end

endmodule

// File: rtl/uwire_rx_shift.sv
`timescale 1ns/1ps
// Incoming word register: shifts the return line in MSB first.
// Shifting DATA_W+1 samples leaves the first (dummy) sample pushed out.
// Assumes din is already synchronous to clk.
module uwire_rx_shift #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              din,
    output logic [DATA_W-1:0] data
);
    // Capture one sample per shift request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data <= '0;
        end else if (shift_en) begin
            data <= {data[DATA_W-2:0], din};
        end
    end

endmodule

// File: rtl/uwire_seq.sv
`timescale 1ns/1ps
// Link sequencer: owns chip select, serial clock, outgoing data and busy.
// Each bit cell is a low half (data valid) then a high half; data changes
// only at the falling edge. After program instructions it drops chip select
// for two halves, raises it again and polls the return line each half.
// Assumes tick comes from a half-period timer cleared on accept.
module uwire_seq
    import uwire_pkg::*;
#(
    parameter int FRAME_W = 25,
    parameter int LW      = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [FRAME_W-1:0] frame,
    input  logic [LW-1:0]      out_len,
    input  logic [LW-1:0]      rx_len,
    input  logic               need_poll,
    input  logic               is_read,
    input  logic               tick,
    input  logic               do_in,
    output logic               tmr_clr,
    output logic               rx_shift,
    output logic               cs_o,
    output logic               sk_o,
    output logic               di_o,
    output logic               busy_o,
    output logic               rd_valid_o
);
    uw_state_e          st;
    logic [FRAME_W-1:0] sh;
    logic [LW-1:0]      cell_idx;
    logic [LW-1:0]      tot_q;
    logic [LW-1:0]      olen_q;
    logic               poll_q;
    logic               read_q;
    logic               gap_half;
    logic               accept;
    logic [LW-1:0]      cell_next;

    assign accept    = (st == ST_IDLE) && cmd_valid;
    assign tmr_clr   = accept;
    assign cell_next = cell_idx + LW'(1);
    assign rx_shift  = (st == ST_LOW) && tick && (cell_idx >= olen_q);

    // Sequence the link phases and hold the command latched for its duration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            sh         <= '0;
            cell_idx   <= '0;
            tot_q      <= '0;
            olen_q     <= '0;
            poll_q     <= 1'b0;
            read_q     <= 1'b0;
            gap_half   <= 1'b0;
            cs_o       <= 1'b0;
            sk_o       <= 1'b0;
            di_o       <= 1'b0;
            busy_o     <= 1'b0;
            rd_valid_o <= 1'b0;
        end else begin
            rd_valid_o <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        sh       <= frame;
                        cell_idx <= '0;
                        tot_q    <= out_len + rx_len;
                        olen_q   <= out_len;
                        poll_q   <= need_poll;
                        read_q   <= is_read;
                        cs_o     <= 1'b1;
                        di_o     <= frame[FRAME_W-1];
                        busy_o   <= 1'b1;
                        st       <= ST_LOW;
                    end
                end
                ST_LOW: begin
                    if (tick) begin
                        sk_o <= 1'b1;
                        st   <= ST_HIGH;
                    end
                end
                ST_HIGH: begin
                    if (tick) begin
                        sk_o     <= 1'b0;
                        cell_idx <= cell_next;
                        if (cell_next == tot_q) begin
                            di_o <= 1'b0;
                            st   <= ST_HOLD;
                        end else begin
                            sh   <= {sh[FRAME_W-2:0], 1'b0};
                            di_o <= sh[FRAME_W-2];
                            st   <= ST_LOW;
                        end
                    end
                end
                ST_HOLD: begin
                    if (tick) begin
                        cs_o <= 1'b0;
                        if (poll_q) begin
                            gap_half <= 1'b0;
                            st       <= ST_GAP;
                        end else begin
                            busy_o     <= 1'b0;
                            rd_valid_o <= read_q;
                            st         <= ST_IDLE;
                        end
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        if (gap_half) begin
                            cs_o <= 1'b1;
                            st   <= ST_POLL;
                        end else begin
                            gap_half <= 1'b1;
                        end
                    end
                end
                ST_POLL: begin
                    if (tick && do_in) begin
                        cs_o   <= 1'b0;
                        busy_o <= 1'b0;
                        st     <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Serial clock only toggles inside a chip-select window
    assert_sk_inside_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sk_o |-> cs_o);

    // Outgoing data is frozen across a whole high phase
    assert_di_stable_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sk_o && $past(sk_o)) |-> $stable(di_o));

    // Read strobe lands exactly on the chip-select drop
    assert_rdv_on_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> ($past(cs_o) && !cs_o));

    // No serial clock while waiting for the ready level
    assert_poll_sk_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_POLL) |-> !sk_o);

    // Chip select never outlives busy
    assert_cs_within_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_o |-> busy_o);

    // An accepted command raises busy on the next cycle
    assert_accept_sets_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && cmd_valid) |=> busy_o);

    // A request during an instruction leaves the latched command untouched
    assert_busy_ignores_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE && cmd_valid) |=> ($stable(tot_q) && $stable(poll_q) && $stable(read_q)));

endmodule

// File: rtl/uwire_eeprom_master.sv
`timescale 1ns/1ps
// Top of the three-wire serial EEPROM master. Wires the command encoder,
// half-period timer, link sequencer and incoming word register together.
// Assumes ee_do is synchronous to clk and HALF_CYC >= 2.
module uwire_eeprom_master
    import uwire_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 16,
    parameter int HALF_CYC = 375
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              busy,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    input  logic              ee_do
);
    localparam int FRAME_W = 3 + ADDR_W + DATA_W;
    localparam int LW      = $clog2(FRAME_W + DATA_W + 2);

    logic [FRAME_W-1:0] frame;
    logic [LW-1:0]      out_len;
    logic [LW-1:0]      rx_len;
    logic               need_poll;
    logic               is_read;
    logic               tick;
    logic               tmr_clr;
    logic               rx_shift;

    uwire_frame_enc #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .FRAME_W(FRAME_W),
        .LW     (LW)
    ) u_enc (
        .op       (uw_op_e'(cmd_op)),
        .addr     (cmd_addr),
        .wdata    (cmd_wdata),
        .frame    (frame),
        .out_len  (out_len),
        .rx_len   (rx_len),
        .need_poll(need_poll),
        .is_read  (is_read)
    );

    uwire_half_timer #(
        .HALF_CYC(HALF_CYC)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (tmr_clr),
        .tick (tick)
    );

    uwire_seq #(
        .FRAME_W(FRAME_W),
        .LW     (LW)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .frame     (frame),
        .out_len   (out_len),
        .rx_len    (rx_len),
        .need_poll (need_poll),
        .is_read   (is_read),
        .tick      (tick),
        .do_in     (ee_do),
        .tmr_clr   (tmr_clr),
        .rx_shift  (rx_shift),
        .cs_o      (ee_cs),
        .sk_o      (ee_sk),
        .di_o      (ee_di),
        .busy_o    (busy),
        .rd_valid_o(rd_valid)
    );

    uwire_rx_shift #(
        .DATA_W(DATA_W)
    ) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(rx_shift),
        .din     (ee_do),
        .data    (rd_data)
    );

endmodule

// File: tb/uwire_eeprom_master_tb.sv
`timescale 1ns/1ps
// Bench: behavioural serial EEPROM model, port monitor, vector table walk,
// then directed tests for ignored commands and reset.
module uwire_eeprom_master_tb;
    localparam int H = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [5:0]  cmd_addr = '0;
    logic [15:0] cmd_wdata = '0;
    logic        busy, rd_valid, ee_cs, ee_sk, ee_di, ee_do;
    logic [15:0] rd_data;

    always #2 clk = ~clk;

    uwire_eeprom_master #(.ADDR_W(6), .DATA_W(16), .HALF_CYC(H)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy),
        .rd_valid(rd_valid), .rd_data(rd_data), .ee_cs(ee_cs), .ee_sk(ee_sk),
        .ee_di(ee_di), .ee_do(ee_do)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // ---------------- EEPROM model ----------------
    logic [15:0] mem [64];
    logic        wr_en = 1'b0;
    logic [8:0]  last_instr = '0;
    logic [15:0] last_wdata = '0;
    int          instr_cnt = 0;
    int          mbits = 0;
    logic [24:0] msr = '0;
    logic        rd_mode = 1'b0;
    int          rd_idx = 0;
    logic [15:0] rd_word = '0;
    logic        pend = 1'b0;
    logic [5:0]  pend_addr = '0;
    logic [15:0] pend_val = '0;
    logic        prog_phase = 1'b0;
    int          rdy_cnt = 0;
    logic        do_rd = 1'b0;

    initial for (int i = 0; i < 64; i++) mem[i] = 16'h8000 | 16'(i);

    always @(posedge ee_sk) if (ee_cs) begin
        msr = {msr[23:0], ee_di};
        mbits++;
        if (mbits == 9) begin
            instr_cnt++;
            last_instr = msr[8:0];
            case (msr[7:6])
                2'b10: begin rd_mode = 1'b1; rd_word = mem[msr[5:0]]; rd_idx = 0; end
                2'b11: begin pend = 1'b1; pend_addr = msr[5:0]; pend_val = 16'hFFFF; end
                2'b00: begin
                    if (msr[5:4] == 2'b11) wr_en = 1'b1;
                    else if (msr[5:4] == 2'b00) wr_en = 1'b0;
                end
                default: ;
            endcase
        end
        if (mbits == 25 && last_instr[7:6] == 2'b01) begin
            last_wdata = msr[15:0];
            pend = 1'b1; pend_addr = last_instr[5:0]; pend_val = msr[15:0];
        end
    end

    always @(negedge ee_sk) if (ee_cs && rd_mode && rd_idx <= 16) begin
        do_rd = (rd_idx == 0) ? 1'b0 : rd_word[16-rd_idx];
        rd_idx++;
    end

    always @(negedge ee_cs) begin
        mbits = 0; msr = '0; rd_mode = 1'b0; do_rd = 1'b0;
        if (pend) begin
            if (wr_en) mem[pend_addr] = pend_val;
            prog_phase = 1'b1;
            pend = 1'b0;
        end else begin
            prog_phase = 1'b0;
        end
    end

    always @(posedge clk) begin
        if (!ee_cs) rdy_cnt <= 0;
        else if (prog_phase && rdy_cnt < 40) rdy_cnt <= rdy_cnt + 1;
    end

    assign ee_do = !ee_cs ? 1'b0 : (prog_phase ? (rdy_cnt >= 40) : do_rd);

    // ---------------- port monitor ----------------
    typedef enum {EV_NONE, EV_CS_RISE, EV_CS_FALL, EV_SK_RISE, EV_SK_FALL} ev_e;
    ev_e  last_ev = EV_NONE;
    int   len = 0, hi_cnt = 0, cs_rises = 0, rd_pulses = 0;
    int   e2 = 0, e3 = 0, e4 = 0, e5 = 0, e6 = 0, e7 = 0;
    logic cs_q = 0, sk_q = 0, di_q = 0, busy_q = 0, rdv_q = 0, do_q = 0;
    logic [15:0] rd_cap = '0;

    always @(negedge clk) begin
        if (!rst_n) begin
            last_ev = EV_NONE; len = 0; hi_cnt = 0;
            cs_q = 0; sk_q = 0; di_q = 0; busy_q = 0; rdv_q = 0; do_q = 0;
        end else begin
            len++;
            if (ee_sk && !sk_q) begin
                if (last_ev == EV_SK_FALL && len != H) e2++;
                if (last_ev == EV_CS_RISE && len != H) e3++;
                last_ev = EV_SK_RISE; len = 0;
            end else if (!ee_sk && sk_q) begin
                if (len != H) e2++;
                last_ev = EV_SK_FALL; len = 0;
            end
            if (ee_sk && !ee_cs) e2++;
            if (ee_cs && !cs_q) begin
                cs_rises++;
                if (last_ev == EV_CS_FALL && busy_q && len != 2*H) e6++;
                last_ev = EV_CS_RISE; len = 0; hi_cnt = 0;
            end else if (!ee_cs && cs_q) begin
                if (last_ev == EV_SK_FALL && len != H) e3++;
                if (last_ev == EV_CS_RISE && (!do_q || hi_cnt > H)) e6++;
                last_ev = EV_CS_FALL; len = 0;
            end
            if (ee_cs && ee_do) hi_cnt++;
            if (ee_sk && sk_q && ee_di != di_q) e4++;
            if (ee_cs && !busy) e7++;
            if (busy_q && !busy && !(cs_q && !ee_cs)) e7++;
            if (rd_valid && rdv_q) e5++;
            if (rd_valid) begin rd_pulses++; rd_cap = rd_data; end
            cs_q = ee_cs; sk_q = ee_sk; di_q = ee_di; busy_q = busy;
            rdv_q = rd_valid; do_q = ee_do;
        end
    end

    // ---------------- helpers ----------------
    function automatic logic [8:0] exp_instr(input logic [2:0] op, input logic [5:0] a);
        case (op)
            3'd0: return {1'b1, 2'b10, a};
            3'd1: return {1'b1, 2'b01, a};
            3'd2: return {1'b1, 2'b11, a};
            3'd3: return {1'b1, 2'b00, 6'b110000};
            default: return {1'b1, 2'b00, 6'b000000};
        endcase
    endfunction

    task automatic issue(input logic [2:0] op, input logic [5:0] a, input logic [15:0] wd);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = wd;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(busy == 1'b1, "R7", "busy after accept", 32'(busy), 32'd1);
    endtask

    task automatic wait_idle();
        int t = 0;
        while (busy && t < 5000) begin @(negedge clk); t++; end
    endtask

    // op(3) addr(6) wdata(16) expected read(16)
    localparam logic [40:0] VEC [12] = '{
        {3'd3, 6'd0,  16'h0000, 16'h0000},
        {3'd1, 6'd5,  16'hA5C3, 16'h0000},
        {3'd0, 6'd5,  16'h0000, 16'hA5C3},
        {3'd1, 6'd63, 16'h1234, 16'h0000},
        {3'd0, 6'd63, 16'h0000, 16'h1234},
        {3'd0, 6'd0,  16'h0000, 16'h8000},
        {3'd2, 6'd5,  16'h0000, 16'h0000},
        {3'd0, 6'd5,  16'h0000, 16'hFFFF},
        {3'd4, 6'd0,  16'h0000, 16'h0000},
        {3'd1, 6'd63, 16'h0000, 16'h0000},
        {3'd0, 6'd63, 16'h0000, 16'h1234},
        {3'd0, 6'd42, 16'h0000, 16'h802A}
    };

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        repeat (5) @(negedge clk);
        // R9: idle outputs while in reset
        chk(!ee_cs && !ee_sk && !ee_di, "R9", "link lines in reset",
            32'({ee_cs, ee_sk, ee_di}), 32'd0);
        chk(!busy && !rd_valid, "R9", "busy/rd_valid in reset", 32'({busy, rd_valid}), 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        for (int i = 0; i < 12; i++) begin
            logic [40:0] v;
            int rises0, pulses0, instr0;
            v = VEC[i];
            rises0 = cs_rises; pulses0 = rd_pulses; instr0 = instr_cnt;
            issue(v[40:38], v[37:32], v[31:16]);
            wait_idle();
            repeat (2) @(negedge clk);
            // R1: instruction bits as the memory received them
            chk(last_instr == exp_instr(v[40:38], v[37:32]), "R1", "instruction frame",
                32'(last_instr), 32'(exp_instr(v[40:38], v[37:32])));
            chk(instr_cnt == instr0 + 1, "R1", "one instruction per command",
                32'(instr_cnt), 32'(instr0 + 1));
            if (v[40:38] == 3'd1)
                chk(last_wdata == v[31:16], "R1", "write payload", 32'(last_wdata), 32'(v[31:16]));
            if (v[40:38] == 3'd0) begin
                chk(rd_pulses == pulses0 + 1, "R5", "one read strobe",
                    32'(rd_pulses), 32'(pulses0 + 1));
                chk(rd_cap == v[15:0], "R5", "read word", 32'(rd_cap), 32'(v[15:0]));
            end
            if (v[40:38] == 3'd1 || v[40:38] == 3'd2)
                chk(cs_rises == rises0 + 2, "R6", "select raised again for polling",
                    32'(cs_rises), 32'(rises0 + 2));
            else
                chk(cs_rises == rises0 + 1, "R10", "single select window",
                    32'(cs_rises), 32'(rises0 + 1));
        end

        // R8: a command during a read is ignored
        begin
            int instr0, pulses0;
            instr0 = instr_cnt; pulses0 = rd_pulses;
            issue(3'd0, 6'd42, 16'h0);
            repeat (30) @(negedge clk);
            cmd_valid = 1'b1; cmd_op = 3'd3; cmd_addr = 6'd7;
            @(negedge clk);
            cmd_valid = 1'b0;
            wait_idle();
            repeat (2) @(negedge clk);
            chk(instr_cnt == instr0 + 1, "R8", "no extra instruction", 32'(instr_cnt), 32'(instr0 + 1));
            chk(last_instr == exp_instr(3'd0, 6'd42), "R8", "read frame intact",
                32'(last_instr), 32'(exp_instr(3'd0, 6'd42)));
            chk(rd_cap == 16'h802A && rd_pulses == pulses0 + 1, "R8", "read result intact",
                32'(rd_cap), 32'h802A);
            chk(!busy && !ee_cs, "R8", "idle after ignored command", 32'({busy, ee_cs}), 32'd0);
        end

        // Accumulated timing checks from the monitor
        chk(e2 == 0, "R2", "serial clock phase length errors", 32'(e2), 32'd0);
        chk(e3 == 0, "R3", "select setup/hold errors", 32'(e3), 32'd0);
        chk(e4 == 0, "R4", "data changes in high phase", 32'(e4), 32'd0);
        chk(e5 == 0, "R5", "read strobe wider than one cycle", 32'(e5), 32'd0);
        chk(e6 == 0, "R6", "gap or poll errors", 32'(e6), 32'd0);
        chk(e7 == 0, "R7", "busy/select mismatches", 32'(e7), 32'd0);

        // R9: reset in the middle of a read
        issue(3'd0, 6'd5, 16'h0);
        repeat (60) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(!ee_cs && !ee_sk && !ee_di && !busy && !rd_valid, "R9", "mid-instruction reset",
            32'({ee_cs, ee_sk, ee_di, busy, rd_valid}), 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        issue(3'd0, 6'd42, 16'h0);
        wait_idle();
        repeat (2) @(negedge clk);
        chk(rd_cap == 16'h802A, "R9", "read after reset recovery", 32'(rd_cap), 32'h802A);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule